// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital control side of a 10-bit successive-approximation converter. Software starts a conversion by writing a start bit through a simple write port. In the same write it also supplies a conversion-clock selection and an acquisition selection. The sequencer may first keep the input sampling for a programmed number of conversion-clock periods. It then runs one setup period and ten bit-decision periods, from the most significant bit down. In each decision period it drives a trial code to the DAC and reads the comparator.

When the last bit is decided, several things happen together: the result register loads, the busy indication drops, a sticky done flag rises and sampling resumes. Writing the start bit low while busy aborts the conversion. An abort leaves the result and the flag untouched.

The conversion clock period is a power-of-two number of system clocks, from 2 to 64, picked by a 3-bit code. Two codes instead take periods from an externally supplied slow-clock tick, which must already be synchronous to `clk`.

The controller has four states:
- IDLE: sampling the input.
- ACQ: timed acquisition, still sampling.
- SETUP: one conversion period with sampling stopped.
- CONV: bit decisions.

The transitions are:
- IDLE→ACQ on a start write with a nonzero acquisition code.
- IDLE→SETUP on a start write with acquisition code 000.
- ACQ→SETUP when the acquisition count ends.
- SETUP→CONV after one period.
- CONV→IDLE after the LSB decision.
- Any busy state→IDLE on an abort write.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`=0, `sample_en`=1, `done_flag`=0, `result`=0, `dac_code`=0.
- R2: Start with acquisition and RC cases:
  - A write with `wr_start`=1 while idle sets `busy` at the write edge.
  - If `wr_acq_sel`=000, `sample_en` falls at that same edge.
  - Whenever idle, `sample_en`=1 and `dac_code`=0.
- R3: With `wr_acq_sel` nonzero, `sample_en` stays 1 for exactly A×N system clocks after the start edge and then falls.
  - N is the conversion period in system clocks.
  - A is the acquisition length: codes 001..111 map to 2, 4, 6, 8, 12, 16 and 20 periods.
  - `busy` stays 1 throughout.
- R4: `wr_clk_sel` sets N by these codes: 000=2, 100=4, 001=8, 101=16, 010=32, 110=64. A conversion without acquisition completes exactly 11×N system clocks after the start edge.
- R5: `wr_clk_sel` codes 011 and 111 time each conversion period by one pulse of `rc_tick`.
- R6: Bit decisions run from MSB to LSB.
  - Each trial bit is set in `dac_code` for one period.
  - The bit is kept if `cmp_in`=1 (input at or above the trial code) at the end of the period, and cleared otherwise.
  - The final code is the largest code not above the input.
- R7: On completion, in a single edge, `result` loads the code, `busy` drops, `done_flag` sets, `sample_en` returns to 1 and `dac_code` returns to 0.
- R8: `result` changes only on completion; during a conversion it holds the previous value.
- R9: A write with `wr_start`=0 while busy returns the block to idle at that edge, with `result` and `done_flag` unchanged.
- R10: `done_flag` stays 1 until a write with `wr_clr_flag`=1; a new start does not clear it.
- R11: `wr_clk_sel` and `wr_acq_sel` are taken only by writes made while idle. Writes while busy do not change the running conversion's timing; a write with `wr_start`=1 while busy does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_start | input | 1 | Start/busy bit value written |
| wr_clr_flag | input | 1 | 1 clears the done flag |
| wr_clk_sel | input | 3 | Conversion clock select code |
| wr_acq_sel | input | 3 | Acquisition length code |
| rc_tick | input | 1 | One-cycle pulse per slow-clock period, synchronous to clk |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC code |
| sample_en | output | 1 | Sample switch enable |
| busy | output | 1 | Start/busy bit readback |
| dac_code | output | RES_BITS | Trial code to the DAC |
| result | output | RES_BITS | Last completed conversion |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The bench models the analog input as a level compared against `dac_code`. It converts the levels 0, full scale, alternating bit patterns, a lone MSB and a lone LSB. Together these show whether each bit is kept or cleared correctly, and in the right order.

Each divider code is run with an exact completion edge, so a wrong code mapping shows up as a wrong completion time. Acquisition codes are checked by the edge at which `sample_en` falls, which tells the ACQ length apart from the conversion length. Separate scenarios cover abort, flag stickiness, locked configuration and RC timing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_SETUP = 2'd2,
        ST_CONV  = 2'd3
    } seq_state_t;

    localparam int MAX_DIV_LOG2 = 6;
    localparam int ACQ_W        = 5;

    // log2 of the divide ratio; code bits [1:0] pick the pair, bit 2 doubles
    function automatic logic [2:0] div_shift(input logic [2:0] sel);
        return 3'd1 + {2'b00, sel[2]} + {sel[1:0], 1'b0};
    endfunction

    function automatic logic use_rc(input logic [2:0] sel);
        return sel[1:0] == 2'b11;
    endfunction

    function automatic logic [ACQ_W-1:0] acq_periods(input logic [2:0] sel);
        logic [ACQ_W-1:0] n;
        unique case (sel)
            3'd0:    n = 5'd0;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd6;
            3'd4:    n = 5'd8;
            3'd5:    n = 5'd12;
            3'd6:    n = 5'd16;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = MAX_DIV_LOG2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    input  logic       rc_tick,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'((32'd1 << div_shift(sel)) - 32'd1);
        if (!run)
            tick = 1'b0;
        else if (use_rc(sel))
            tick = rc_tick;
        else
            tick = (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                begin_conv,
    input  logic                step,
    input  logic                commit,
    input  logic                flush,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] result,
    output logic                last
);

    localparam int IDX_W = $clog2(RES_BITS);
    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_BITS - 1);

    logic [IDX_W-1:0]    idx_q;
    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] res_q;
    logic [RES_BITS-1:0] decided;
    logic [RES_BITS-1:0] next_trial;

    // resolve the bit under trial, and place the following trial bit
    always_comb begin
        decided        = code_q;
        decided[idx_q] = cmp_in;
        next_trial     = '0;
        if (idx_q != '0)
            next_trial[idx_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            res_q  <= '0;
            idx_q  <= '0;
        end else if (flush || commit) begin
            code_q <= '0;
            idx_q  <= '0;
            if (commit && !flush)
                res_q <= decided;
        end else if (begin_conv) begin
            code_q          <= '0;
            code_q[MSB_IDX] <= 1'b1;
            idx_q           <= MSB_IDX;
        end else if (step) begin
            code_q <= decided | next_trial;
            idx_q  <= idx_q - 1'b1;
        end
    end

    assign code   = code_q;
    assign result = res_q;
    assign last   = (idx_q == '0);

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_start,
    input  logic                wr_clr_flag,
    input  logic [2:0]          wr_clk_sel,
    input  logic [2:0]          wr_acq_sel,
    input  logic                rc_tick,
    input  logic                cmp_in,
    output logic                sample_en,
    output logic                busy,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                done_flag
);

    seq_state_t       state_q, state_d;
    logic [2:0]       clk_sel_q, acq_sel_q;
    logic [ACQ_W-1:0] acq_cnt_q, acq_len;
    logic             tick, last, flag_q;
    logic             start_req, abort_req;
    logic             begin_conv, step, commit;

    assign start_req = wr_en && wr_start  && (state_q == ST_IDLE);
    assign abort_req = wr_en && !wr_start && (state_q != ST_IDLE);
    assign acq_len   = acq_periods(acq_sel_q);

    adc_tad_gen #(.CNT_W(MAX_DIV_LOG2)) u_tad (
        .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE),
        .sel(clk_sel_q), .rc_tick(rc_tick), .tick(tick)
    );

    adc_sar_reg #(.RES_BITS(RES_BITS)) u_sar (
        .clk(clk), .rst_n(rst_n), .begin_conv(begin_conv), .step(step),
        .commit(commit), .flush(abort_req), .cmp_in(cmp_in),
        .code(dac_code), .result(result), .last(last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (abort_req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_req)
                              state_d = (wr_acq_sel == 3'd0) ? ST_SETUP : ST_ACQ;
                ST_ACQ:   if (tick && acq_cnt_q == acq_len - 1'b1)
                              state_d = ST_SETUP;
                ST_SETUP: if (tick) state_d = ST_CONV;
                ST_CONV:  if (tick && last) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            clk_sel_q <= 3'd0;
            acq_sel_q <= 3'd0;
            acq_cnt_q <= '0;
            flag_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_en && state_q == ST_IDLE) begin
                clk_sel_q <= wr_clk_sel;
                acq_sel_q <= wr_acq_sel;
            end
            if (state_q != ST_ACQ)
                acq_cnt_q <= '0;
            else if (tick)
                acq_cnt_q <= acq_cnt_q + 1'b1;
            if (commit)
                flag_q <= 1'b1;
            else if (wr_en && wr_clr_flag)
                flag_q <= 1'b0;
        end
    end

    // outputs and datapath controls
    always_comb begin
        sample_en  = 1'b0;
        busy       = 1'b1;
        begin_conv = 1'b0;
        step       = 1'b0;
        commit     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sample_en = 1'b1;
                busy      = 1'b0;
            end
            ST_ACQ:   sample_en  = 1'b1;
            ST_SETUP: begin_conv = tick && !abort_req;
            ST_CONV: begin
                step   = tick && !abort_req && !last;
                commit = tick && !abort_req && last;
            end
            default: ;
        endcase
    end

    assign done_flag = flag_q;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_start,
    input logic                wr_clr_flag,
    input logic                sample_en,
    input logic                busy,
    input logic [RES_BITS-1:0] dac_code,
    input logic [RES_BITS-1:0] result,
    input logic                done_flag
);

    assert_idle_samples_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sample_en && dac_code == '0));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_start) |=> busy);

    assert_done_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($fell(busy) && sample_en));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !wr_start) |=> (!busy && $stable(result) && $stable(done_flag)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !(wr_en && wr_clr_flag)) |=> done_flag);

endmodule

bind adc_sar_sequencer adc_seq_checker #(.RES_BITS(RES_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
    .wr_clr_flag(wr_clr_flag), .sample_en(sample_en), .busy(busy),
    .dac_code(dac_code), .result(result), .done_flag(done_flag)
);

// File: tb/sim_adc_sar_sequencer.sv
`timescale 1ns/1ps
module sim_adc_sar_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_start = 1'b0, wr_clr_flag = 1'b0;
    logic [2:0] wr_clk_sel = 3'd0, wr_acq_sel = 3'd0;
    logic       rc_tick = 1'b0;
    logic       cmp_in;
    logic       sample_en, busy, done_flag;
    logic [9:0] dac_code, result;
    logic [9:0] analog_v = 10'd0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    // analog stand-in: comparator is 1 when input is at or above the trial code
    assign cmp_in = (dac_code <= analog_v);

    adc_sar_sequencer #(.RES_BITS(10)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
        .wr_clr_flag(wr_clr_flag), .wr_clk_sel(wr_clk_sel), .wr_acq_sel(wr_acq_sel),
        .rc_tick(rc_tick), .cmp_in(cmp_in), .sample_en(sample_en), .busy(busy),
        .dac_code(dac_code), .result(result), .done_flag(done_flag)
    );

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            rc_tick = 1'b1;
            @(negedge clk);
            rc_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write lands on the next rising edge; returns half a cycle after it
    task automatic wr(input logic st, input logic clr, input logic [2:0] cs, input logic [2:0] aq);
        @(negedge clk);
        wr_en = 1'b1; wr_start = st; wr_clr_flag = clr; wr_clk_sel = cs; wr_acq_sel = aq;
        @(negedge clk);
        wr_en = 1'b0; wr_start = 1'b0; wr_clr_flag = 1'b0;
    endtask

    task automatic run_conv(input string tag, input int v, input logic [2:0] cs,
                            input logic [2:0] aq, input int n, input int a);
        int total;
        logic [9:0] prev;
        analog_v = 10'(v);
        prev  = result;
        total = (a + 11) * n;
        wr(1'b1, 1'b0, cs, aq);
        chk(busy == 1'b1, {tag, " R2 busy at start"}, busy, 1);
        if (a == 0) begin
            chk(sample_en == 1'b0, {tag, " R2 sampling stops"}, sample_en, 0);
        end else begin
            waitn(a * n - 1);
            chk(sample_en == 1'b1, {tag, " R3 still acquiring"}, sample_en, 1);
            waitn(1);
            chk(sample_en == 1'b0, {tag, " R3 acquisition ends"}, sample_en, 0);
            chk(busy == 1'b1, {tag, " R3 busy through acquisition"}, busy, 1);
            total = total - a * n;
        end
        waitn(total - 1);
        chk(busy == 1'b1, {tag, " R4 busy one clock before end"}, busy, 1);
        chk(result == prev, {tag, " R8 old result held"}, result, prev);
        waitn(1);
        chk(busy == 1'b0, {tag, " R4 done on time"}, busy, 0);
        chk(result == 10'(v), {tag, " R6 code"}, result, v);
        chk(done_flag == 1'b1, {tag, " R7 flag set"}, done_flag, 1);
        chk(sample_en == 1'b1 && dac_code == 10'd0, {tag, " R7 back to sampling"}, sample_en, 1);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(sample_en == 1'b1, "R1 sample_en", sample_en, 1);
        chk(done_flag == 1'b0, "R1 flag", done_flag, 0);
        chk(result == 10'd0, "R1 result", result, 0);
        chk(dac_code == 10'd0, "R1 dac", dac_code, 0);
    endtask

    task automatic t_dividers;
        run_conv("div2",  682,  3'b000, 3'b000, 2, 0);
        run_conv("div4",  1023, 3'b100, 3'b000, 4, 0);
        run_conv("div8",  0,    3'b001, 3'b000, 8, 0);
        run_conv("div16", 341,  3'b101, 3'b000, 16, 0);
        run_conv("div32", 512,  3'b010, 3'b000, 32, 0);
        run_conv("div64", 1,    3'b110, 3'b000, 64, 0);
    endtask

    task automatic t_acq;
        run_conv("acq2",  100, 3'b000, 3'b001, 2, 2);
        run_conv("acq20", 900, 3'b100, 3'b111, 4, 20);
        run_conv("acq12", 513, 3'b000, 3'b101, 2, 12);
    endtask

    task automatic t_flag;
        // flag is 1 from the previous conversion; a new start keeps it (R10)
        analog_v = 10'd77;
        wr(1'b1, 1'b0, 3'b000, 3'b000);
        chk(done_flag == 1'b1, "R10 start keeps flag", done_flag, 1);
        waitn(21);
        chk(done_flag == 1'b1, "R10 flag held during conv", done_flag, 1);
        wr(1'b0, 1'b1, 3'b000, 3'b000);
        chk(done_flag == 1'b0, "R10 clear write", done_flag, 0);
        chk(result == 10'd77, "R6 result after flag test", result, 77);
    endtask

    task automatic t_abort;
        analog_v = 10'd600;
        wr(1'b1, 1'b0, 3'b100, 3'b000);
        waitn(10);
        wr(1'b0, 1'b0, 3'b100, 3'b000);
        chk(busy == 1'b0, "R9 abort idle", busy, 0);
        chk(sample_en == 1'b1, "R9 abort sampling", sample_en, 1);
        chk(result == 10'd77, "R9 result unchanged", result, 77);
        chk(done_flag == 1'b0, "R9 flag not set", done_flag, 0);
        waitn(60);
        chk(done_flag == 1'b0 && result == 10'd77, "R9 nothing completes later", result, 77);
        wr(1'b1, 1'b0, 3'b000, 3'b110);
        waitn(5);
        wr(1'b0, 1'b0, 3'b000, 3'b000);
        chk(busy == 1'b0 && sample_en == 1'b1, "R9 abort in acquisition", busy, 0);
    endtask

    task automatic t_cfg_lock;
        analog_v = 10'd300;
        wr(1'b1, 1'b0, 3'b000, 3'b000);
        waitn(3);
        // busy write with start kept: fields ignored, no restart
        wr(1'b1, 1'b0, 3'b110, 3'b111);
        waitn(21 - 5);
        chk(busy == 1'b1, "R11 still busy at 21", busy, 1);
        waitn(1);
        chk(busy == 1'b0, "R11 timing unchanged", busy, 0);
        chk(result == 10'd300, "R11 result", result, 300);
    endtask

    task automatic t_rc;
        int k;
        analog_v = 10'd777;
        wr(1'b1, 1'b1, 3'b011, 3'b000);
        k = 0;
        while (busy && k < 200) begin
            waitn(1);
            k++;
        end
        chk(k >= 29 && k <= 34, "R5 rc period count", k, 32);
        chk(result == 10'd777, "R5 rc result", result, 777);
        analog_v = 10'd5;
        wr(1'b1, 1'b0, 3'b111, 3'b000);
        k = 0;
        while (busy && k < 200) begin
            waitn(1);
            k++;
        end
        chk(k >= 29 && k <= 34, "R5 rc code 111 period count", k, 32);
        chk(result == 10'd5, "R5 rc code 111 result", result, 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        waitn(3);
        t_reset();
        rst_n = 1'b1;
        waitn(2);
        t_reset();
        t_dividers();
        t_acq();
        t_flag();
        t_abort();
        t_cfg_lock();
        t_rc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule